// File: doc/BRIEF.md
# Linked Descriptor Chain Walker

This block is the sequencer of one DMA channel working in link mode. Software builds a chain of fixed-size descriptors in memory, each one describing a single copy segment, and hands the channel the byte address of the first entry. The walker fetches that descriptor word by word and first checks the valid flag in its header. It then captures the segment's source, destination, byte count, per-segment configuration and the address of the next entry. It copies the data through a simple word request/acknowledge memory port and writes the header back with the valid flag cleared. Finally it follows the next-link address.

The chain ends at the first descriptor whose valid flag is clear, so software can keep a circular ring and append entries while the channel runs: consumed entries come back invalid, and the walker parks on them. A segment whose configuration has the link-mode bit clear also ends the chain after it has been retired. Each segment may ask for a one-cycle end interrupt. A memory error response aborts the chain and leaves an error flag set until the next start.

Descriptor layout (32-bit words, 32-byte stride): word 0 header (bit 0 valid), word 1 source address, word 2 destination address, word 3 byte count, word 4 configuration, words 5 and 6 not used by this sequencer, word 7 next-link byte address. Each copy beat moves one 32-bit word.

Top module: `dcw_chain_walker`

## Requirements
- R1: While idle, a one-cycle `start_i` makes `active_o` high from the next cycle, and the first memory request is a read of the descriptor at `link_addr_i`. Words are read at increasing addresses of 4 bytes each, header first. `err_o` is cleared by this start.
- R2: If the fetched header has bit 0 clear, the walker reads no further word of that descriptor and drops `active_o`. It makes no write, raises no interrupt and leaves `err_o` low.
- R3: A segment with byte count N performs ceil(N/4) beats. Each beat is one read from the source address followed by one write of that word to the destination address. The beats are issued in order, and each address advances by 4 per beat.
- R4: Configuration bit 20 set keeps the source address fixed for every beat. Configuration bit 21 set keeps the destination address fixed for every beat.
- R5: After the last beat of a segment, the header word is written back to the descriptor's base address with bit 0 cleared and every other bit unchanged.
- R6: After retiring a segment whose configuration bit 31 is set, the next descriptor is fetched from the address held in word 7. A chain closed into a ring therefore wraps back to its first entry.
- R7: `end_irq_o` pulses for exactly one cycle after the retire write of a segment whose configuration bit 24 is set. It does not pulse for segments with bit 24 clear.
- R8: After retiring a segment whose configuration bit 31 is clear, the walker stops even if word 7 points at a valid descriptor.
- R9: A byte count of 0 retires the descriptor straight after the fetch, with no source read and no destination write.
- R10: A memory response with `mem_err_i` set aborts the chain at once: `err_o` becomes 1, `active_o` drops, no further request is made and the descriptor is not retired.
- R11: Once raised, `mem_req_o` stays high with a stable address, direction and write data until `mem_ack_i` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle start pulse, taken only while idle |
| link_addr_i | input | AW | Byte address of the first descriptor |
| active_o | output | 1 | Channel enabled, chain being walked |
| err_o | output | 1 | Chain aborted by a memory error |
| end_irq_o | output | 1 | One-cycle end-of-segment interrupt |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | AW | Byte address of the word access |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Access completed this cycle |
| mem_err_i | input | 1 | Error response, valid with `mem_ack_i` |
| mem_rdata_i | input | 32 | Read data, valid with `mem_ack_i` |

## Verification
The bench goes after the stop conditions. It walks a three-entry ring back onto an entry the walker has already retired; a walker that ignored the valid flag would replay the first segment forever. It also ends a chain with the link bit clear while a valid entry waits at the next address; a walker that skipped this check would fetch that entry. A zero-length segment and a byte count that is not a multiple of four with a fixed source check the beat count: an off-by-one design shows extra or missing writes in the scoreboard, and a fixed-address bug writes to the wrong words. An error injected in the middle of a copy checks that the walker makes no further request and does not retire the descriptor, and that the following start clears the error flag.

// File: rtl/dcw_pkg.sv
package dcw_pkg;

  localparam int unsigned WORD_W = 32;

  // word index inside a descriptor
  localparam logic [2:0] WI_HDR = 3'd0;
  localparam logic [2:0] WI_SRC = 3'd1;
  localparam logic [2:0] WI_DST = 3'd2;
  localparam logic [2:0] WI_CNT = 3'd3;
  localparam logic [2:0] WI_CFG = 3'd4;
  localparam logic [2:0] WI_NXT = 3'd7;

  // configuration bit positions decoded by the walker
  localparam int unsigned CB_LINK = 31;
  localparam int unsigned CB_IRQ  = 24;
  localparam int unsigned CB_DFIX = 21;
  localparam int unsigned CB_SFIX = 20;

  typedef struct packed {
    logic link;
    logic irq;
    logic dfix;
    logic sfix;
  } seg_cfg_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_RD,
    ST_WR,
    ST_RETIRE
  } walk_state_e;

endpackage

// File: rtl/dcw_addr_ptr.sv
module dcw_addr_ptr #(
  parameter int unsigned AW   = 32,
  parameter int unsigned STEP = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [AW-1:0] load_val_i,
  input  logic          step_i,
  input  logic          hold_i,
  output logic [AW-1:0] addr_o
);

  logic [AW-1:0] addr_q, addr_d;
  logic          addr_en;

  always_comb begin
    addr_en = load_i | (step_i & ~hold_i);
    addr_d  = load_i ? load_val_i : addr_q + AW'(STEP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  assign addr_o = addr_q;

endmodule

// File: rtl/dcw_beat_ctr.sv
module dcw_beat_ctr #(
  parameter int unsigned BYTES_W = 32,
  parameter int unsigned WORD_B  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic [BYTES_W-1:0] bytes_i,
  input  logic               dec_i,
  output logic               last_o,
  output logic               zero_o
);

  localparam int unsigned SH  = $clog2(WORD_B);
  localparam int unsigned RW  = BYTES_W - SH + 1;

  logic [RW-1:0] rem_q, rem_d;
  logic          rem_en;

  always_comb begin
    rem_en = load_i | dec_i;
    if (load_i)
      rem_d = RW'(bytes_i >> SH) + RW'(|bytes_i[SH-1:0]);
    else
      rem_d = rem_q - RW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rem_q <= '0;
    else if (rem_en) rem_q <= rem_d;
  end

  assign last_o = (rem_q == RW'(1));
  assign zero_o = (rem_q == '0);

  assert_beat_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_i && !load_i) |-> !zero_o);

endmodule

// File: rtl/dcw_chain_walker.sv
module dcw_chain_walker
  import dcw_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [AW-1:0]     link_addr_i,
  output logic              active_o,
  output logic              err_o,
  output logic              end_irq_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic              mem_err_i,
  input  logic [WORD_W-1:0] mem_rdata_i
);

  localparam int unsigned WORD_B = WORD_W / 8;

  walk_state_e       state_q, state_d;
  logic [2:0]        idx_q, idx_d;
  logic [AW-1:0]     base_q, base_d;
  logic [AW-1:0]     nxt_q, nxt_d;
  logic [WORD_W-1:0] hdr_q, hdr_d;
  logic [WORD_W-1:0] buf_q, buf_d;
  seg_cfg_t          cfg_q, cfg_d;
  logic              err_q, err_d;
  logic              irq_q, irq_d;

  logic src_ld, dst_ld, src_step, dst_step, cnt_ld, cnt_dec;
  logic cnt_last, cnt_zero;
  logic ok_ack;

  logic [1:0]    ptr_ld, ptr_step, ptr_hold;
  logic [AW-1:0] ptr_addr [2];

  assign ptr_ld   = {dst_ld, src_ld};
  assign ptr_step = {dst_step, src_step};
  assign ptr_hold = {cfg_q.dfix, cfg_q.sfix};

  // index 0: source pointer, index 1: destination pointer
  for (genvar gi = 0; gi < 2; gi++) begin : g_ptr
    dcw_addr_ptr #(.AW(AW), .STEP(WORD_B)) u_ptr (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (ptr_ld[gi]),
      .load_val_i (mem_rdata_i[AW-1:0]),
      .step_i     (ptr_step[gi]),
      .hold_i     (ptr_hold[gi]),
      .addr_o     (ptr_addr[gi])
    );
  end

  dcw_beat_ctr #(.BYTES_W(WORD_W), .WORD_B(WORD_B)) u_beats (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (cnt_ld),
    .bytes_i (mem_rdata_i),
    .dec_i   (cnt_dec),
    .last_o  (cnt_last),
    .zero_o  (cnt_zero)
  );

  assign ok_ack = mem_ack_i & ~mem_err_i;

  // next-state logic
  always_comb begin
    state_d  = state_q;
    idx_d    = idx_q;
    base_d   = base_q;
    nxt_d    = nxt_q;
    hdr_d    = hdr_q;
    buf_d    = buf_q;
    cfg_d    = cfg_q;
    err_d    = err_q;
    irq_d    = 1'b0;
    src_ld   = 1'b0;
    dst_ld   = 1'b0;
    src_step = 1'b0;
    dst_step = 1'b0;
    cnt_ld   = 1'b0;
    cnt_dec  = 1'b0;
    if (state_q == ST_IDLE) begin
      if (start_i) begin
        state_d = ST_FETCH;
        idx_d   = '0;
        base_d  = link_addr_i;
        err_d   = 1'b0;
      end
    end else if (mem_ack_i && mem_err_i) begin
      state_d = ST_IDLE;
      err_d   = 1'b1;
    end else if (ok_ack) begin
      case (state_q)
        ST_FETCH: begin
          idx_d = idx_q + 3'd1;
          case (idx_q)
            WI_HDR: begin
              hdr_d = mem_rdata_i;
              if (!mem_rdata_i[0]) state_d = ST_IDLE;
            end
            WI_SRC: src_ld = 1'b1;
            WI_DST: dst_ld = 1'b1;
            WI_CNT: cnt_ld = 1'b1;
            WI_CFG: cfg_d = '{link: mem_rdata_i[CB_LINK], irq: mem_rdata_i[CB_IRQ],
                              dfix: mem_rdata_i[CB_DFIX], sfix: mem_rdata_i[CB_SFIX]};
            WI_NXT: begin
              nxt_d   = mem_rdata_i[AW-1:0];
              state_d = cnt_zero ? ST_RETIRE : ST_RD;
            end
            default: ;
          endcase
        end
        ST_RD: begin
          buf_d    = mem_rdata_i;
          src_step = 1'b1;
          state_d  = ST_WR;
        end
        ST_WR: begin
          dst_step = 1'b1;
          cnt_dec  = 1'b1;
          state_d  = cnt_last ? ST_RETIRE : ST_RD;
        end
        ST_RETIRE: begin
          irq_d = cfg_q.irq;
          if (cfg_q.link) begin
            state_d = ST_FETCH;
            base_d  = nxt_q;
            idx_d   = '0;
          end else begin
            state_d = ST_IDLE;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      base_q  <= '0;
      nxt_q   <= '0;
      hdr_q   <= '0;
      buf_q   <= '0;
      cfg_q   <= '0;
      err_q   <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      base_q  <= base_d;
      nxt_q   <= nxt_d;
      hdr_q   <= hdr_d;
      buf_q   <= buf_d;
      cfg_q   <= cfg_d;
      err_q   <= err_d;
      irq_q   <= irq_d;
    end
  end

  // memory port
  always_comb begin
    mem_req_o   = 1'b1;
    mem_we_o    = 1'b0;
    mem_addr_o  = base_q;
    mem_wdata_o = '0;
    case (state_q)
      ST_FETCH:  mem_addr_o = base_q + (AW'(idx_q) << 2);
      ST_RD:     mem_addr_o = ptr_addr[0];
      ST_WR: begin
        mem_we_o    = 1'b1;
        mem_addr_o  = ptr_addr[1];
        mem_wdata_o = buf_q;
      end
      ST_RETIRE: begin
        mem_we_o    = 1'b1;
        mem_wdata_o = {hdr_q[WORD_W-1:1], 1'b0};
      end
      default:   mem_req_o = 1'b0;
    endcase
  end

  assign active_o  = (state_q != ST_IDLE);
  assign err_o     = err_q;
  assign end_irq_o = irq_q;

  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) &&
                                   $stable(mem_we_o) && $stable(mem_wdata_o)));

  assert_irq_after_retire_R7: assert property (@(posedge clk) disable iff (!rst_n)
    end_irq_o |-> $past(state_q == ST_RETIRE && ok_ack));

  assert_invalid_stops_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FETCH && idx_q == WI_HDR && ok_ack && !mem_rdata_i[0])
      |=> (!active_o && !err_o && !end_irq_o));

  assert_err_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (!active_o && !mem_req_o));

  assert_zero_skips_copy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FETCH && idx_q == WI_NXT && ok_ack && cnt_zero)
      |=> (mem_we_o && mem_addr_o == base_q));

endmodule

// File: tb/tb_dcw_chain_walker.sv
module tb_dcw_chain_walker;

  localparam int unsigned AW = 32;

  logic          clk;
  logic          rst_n;
  logic          start_i;
  logic [AW-1:0] link_addr_i;
  logic          active_o, err_o, end_irq_o;
  logic          mem_req_o, mem_we_o;
  logic [AW-1:0] mem_addr_o;
  logic [31:0]   mem_wdata_o;
  logic          mem_ack_i, mem_err_i;
  logic [31:0]   mem_rdata_i;

  dcw_chain_walker #(.AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .link_addr_i(link_addr_i),
    .active_o(active_o), .err_o(err_o), .end_irq_o(end_irq_o),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i), .mem_err_i(mem_err_i),
    .mem_rdata_i(mem_rdata_i)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  logic [31:0] mem [1024];
  logic [31:0] exp_addr_q [$];
  logic [31:0] exp_data_q [$];
  logic [31:0] err_addr;
  int          checks, errors, rd_cnt, irq_cnt, cycles;
  string       cur_tag;

  function automatic logic [31:0] dat(input logic [31:0] a);
    return 32'hC0DE_0000 | (a >> 2);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // driver side of the scoreboard
  task automatic expect_wr(input logic [31:0] a, input logic [31:0] d);
    exp_addr_q.push_back(a);
    exp_data_q.push_back(d);
  endtask

  // memory model and write monitor
  always @(negedge clk) begin
    if (mem_ack_i) begin
      mem_ack_i = 1'b0;
      mem_err_i = 1'b0;
    end else if (mem_req_o) begin
      mem_ack_i = 1'b1;
      if (mem_addr_o == err_addr) begin
        mem_err_i   = 1'b1;
        mem_rdata_i = 32'hDEAD_BEEF;
        if (!mem_we_o) rd_cnt++;
      end else if (mem_we_o) begin
        if (exp_addr_q.size() == 0) begin
          chk(1'b0, {cur_tag, " unexpected write"}, mem_addr_o, 32'hFFFF_FFFF);
        end else begin
          logic [31:0] ea, ed;
          ea = exp_addr_q.pop_front();
          ed = exp_data_q.pop_front();
          chk(mem_addr_o == ea, {cur_tag, " write address"}, mem_addr_o, ea);
          chk(mem_wdata_o == ed, {cur_tag, " write data"}, mem_wdata_o, ed);
        end
        mem[mem_addr_o[11:2]] = mem_wdata_o;
      end else begin
        mem_rdata_i = mem[mem_addr_o[11:2]];
        rd_cnt++;
      end
    end
    if (end_irq_o) irq_cnt++;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic put_desc(input logic [31:0] b, input logic [31:0] hdr,
                          input logic [31:0] src, input logic [31:0] dst,
                          input logic [31:0] cnt, input logic [31:0] cfg,
                          input logic [31:0] nxt);
    mem[(b >> 2) + 0] = hdr;
    mem[(b >> 2) + 1] = src;
    mem[(b >> 2) + 2] = dst;
    mem[(b >> 2) + 3] = cnt;
    mem[(b >> 2) + 4] = cfg;
    mem[(b >> 2) + 5] = 32'h0;
    mem[(b >> 2) + 6] = 32'h0;
    mem[(b >> 2) + 7] = nxt;
  endtask

  task automatic run_chain(input logic [31:0] a, input string tag);
    cur_tag = tag;
    rd_cnt  = 0;
    irq_cnt = 0;
    @(negedge clk);
    start_i     = 1'b1;
    link_addr_i = a;
    @(negedge clk);
    start_i = 1'b0;
    chk(active_o == 1'b1, "R1 active after start", 32'(active_o), 32'h1);
    chk(mem_req_o && !mem_we_o && mem_addr_o == a, "R1 first fetch address",
        mem_addr_o, a);
    chk(err_o == 1'b0, "R1 error cleared by start", 32'(err_o), 32'h0);
    for (int i = 0; i < 3000 && active_o; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(exp_addr_q.size() == 0, {tag, " all expected writes seen"},
        32'(exp_addr_q.size()), 32'h0);
    exp_addr_q.delete();
    exp_data_q.delete();
  endtask

  initial begin
    checks = 0; errors = 0; cycles = 0; rd_cnt = 0; irq_cnt = 0;
    cur_tag = "reset";
    err_addr = 32'hFFFF_FFFF;
    start_i = 1'b0; link_addr_i = '0;
    mem_ack_i = 1'b0; mem_err_i = 1'b0; mem_rdata_i = '0;
    for (int i = 0; i < 1024; i++) mem[i] = 32'hC0DE_0000 | 32'(i);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!active_o && !err_o && !end_irq_o && !mem_req_o, "reset outputs idle",
        {28'h0, active_o, err_o, end_irq_o, mem_req_o}, 32'h0);

    // ring of three: incrementing copy, zero length, fixed source with irq
    put_desc(32'h100, 32'h0000_5A01, 32'h400, 32'h600, 32'd12, 32'h8000_0000, 32'h120);
    put_desc(32'h120, 32'h0000_0003, 32'h000, 32'h000, 32'd0,  32'h8000_0000, 32'h140);
    put_desc(32'h140, 32'h0000_0001, 32'h480, 32'h700, 32'd5,  32'h8110_0000, 32'h100);
    expect_wr(32'h600, dat(32'h400));  // R3 incrementing beats
    expect_wr(32'h604, dat(32'h404));
    expect_wr(32'h608, dat(32'h408));
    expect_wr(32'h100, 32'h0000_5A00); // R5 retire keeps other header bits
    expect_wr(32'h120, 32'h0000_0002); // R9 zero count: retire only
    expect_wr(32'h700, dat(32'h480));  // R4 fixed source, 5 bytes = 2 beats
    expect_wr(32'h704, dat(32'h480));
    expect_wr(32'h140, 32'h0000_0000);
    run_chain(32'h100, "R6 ring walk");
    chk(rd_cnt == 30, "R9 read count, zero segment makes no copy reads", rd_cnt, 30);
    chk(irq_cnt == 1, "R7 one interrupt for the ring", irq_cnt, 1);
    chk(!active_o && !err_o, "R2 stop on retired ring entry",
        {30'h0, active_o, err_o}, 32'h0);
    chk(mem[32'h140 >> 2] == 32'h0, "R5 last header retired", mem[32'h140 >> 2], 32'h0);

    // single segment: link bit clear, fixed destination, irq
    put_desc(32'h200, 32'h0000_0011, 32'h800, 32'h900, 32'd8, 32'h0120_0000, 32'h220);
    put_desc(32'h220, 32'h0000_0001, 32'h800, 32'h980, 32'd4, 32'h8000_0000, 32'h220);
    expect_wr(32'h900, dat(32'h800));  // R4 fixed destination
    expect_wr(32'h900, dat(32'h804));
    expect_wr(32'h200, 32'h0000_0010);
    run_chain(32'h200, "R8 single segment");
    chk(rd_cnt == 10, "R8 no fetch past unlinked segment", rd_cnt, 10);
    chk(mem[32'h220 >> 2] == 32'h1, "R8 next entry untouched", mem[32'h220 >> 2], 32'h1);
    chk(irq_cnt == 1, "R7 interrupt on bit 24", irq_cnt, 1);

    // error on second source read
    put_desc(32'h300, 32'h0000_0001, 32'hA00, 32'hB00, 32'd8, 32'h8100_0000, 32'h300);
    err_addr = 32'hA04;
    expect_wr(32'hB00, dat(32'hA00));
    run_chain(32'h300, "R10 error abort");
    chk(err_o == 1'b1, "R10 error flag set", 32'(err_o), 32'h1);
    chk(!active_o && !mem_req_o, "R10 channel stopped, no request",
        {30'h0, active_o, mem_req_o}, 32'h0);
    chk(rd_cnt == 10, "R10 no read after error", rd_cnt, 10);
    chk(mem[32'h300 >> 2] == 32'h1, "R10 descriptor not retired", mem[32'h300 >> 2], 32'h1);
    chk(irq_cnt == 0, "R10 no interrupt on abort", irq_cnt, 0);
    err_addr = 32'hFFFF_FFFF;

    // invalid header right away
    put_desc(32'h3A0, 32'h0000_0FF0, 32'hA00, 32'hB00, 32'd8, 32'h8100_0000, 32'h3A0);
    run_chain(32'h3A0, "R2 invalid header");
    chk(rd_cnt == 1, "R2 only header read", rd_cnt, 1);
    chk(!err_o && irq_cnt == 0, "R2 no error, no interrupt",
        {31'h0, err_o} | 32'(irq_cnt), 32'h0);
    chk(mem[32'h3A0 >> 2] == 32'h0000_0FF0, "R2 header not written",
        mem[32'h3A0 >> 2], 32'h0000_0FF0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule